// File: doc/BRIEF.md
# Classifier Supervisory Controller

This block is the digital sequencer that sits next to an analog nearest-prototype / kernel classifier array. It reads everything it needs from a read-only configuration memory, which is reached through a simple combinational read port. At power-up it can run a serial self-test of the array's scan chain. It then writes the decoder and kernel width/slope settings, pulses the row/column pointer reset and downloads every prototype value into the cells.

After initialisation it alternates between two modes. In classify mode the array is enabled for a fixed number of clock cycles. In refresh mode the analog memory is restored. A mode switch selects between two kinds of refresh. With internal refresh, the controller only raises the refresh request and waits for the array to report completion. With external refresh, the controller streams the stored prototype words back into the cells itself.

The state machine has eleven states: BOOT, FILL, DRAIN, VERDICT, HALT, CFG, PTR, LOAD, RUN, IREF and XREF. Its transitions are as follows:
- BOOT goes to FILL when the test switch is on, otherwise to CFG.
- FILL goes to DRAIN, and DRAIN goes to VERDICT, each after SCAN_LEN cycles.
- VERDICT goes to HALT on a recorded mismatch, otherwise to CFG.
- HALT is terminal until reset.
- CFG goes to PTR after CFG_WORDS writes.
- PTR goes to LOAD after one cycle.
- LOAD goes to RUN after N_PROTO writes.
- RUN goes to IREF or XREF when the interval expires, chosen by the refresh switch.
- IREF goes to RUN on refresh done.
- XREF goes to RUN after N_PROTO writes.

Memory layout, by word address:
- Words 0..SCAN_LEN-1 hold the scan pattern, in bit 0 of each word.
- The next CFG_WORDS words hold configuration.
- The last N_PROTO words hold the prototypes.

Top module: `clsup_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after its release, cfg_we, cell_we, ptr_rst, scan_en, cls_en, ref_req and test_fail are all 0.
- R2: With sw_test = 1, the scan self-test runs in two phases of SCAN_LEN cycles each, with scan_en high in both.
  - In the first phase, cycle k drives scan_sdo with bit 0 of memory word k.
  - In the second phase, cycle k drives scan_sdo = 0 and compares scan_sdi against bit 0 of word k.
  - No other strobe is active while scan_en is high.
- R3: Any mismatch in the compare phase sets test_fail. test_fail stays 1 until reset, and from then on no config write, cell write, classify enable or refresh request occurs.
- R4: With sw_test = 0 at reset release, scan_en never rises and initialisation proceeds directly to configuration.
- R5: The configuration phase issues exactly CFG_WORDS writes in consecutive cycles. Write k has cfg_sel = k and cfg_data = word SCAN_LEN+k. All config writes precede any cell write.
- R6: ptr_rst is a single-cycle pulse. It follows the last config write and is immediately followed by the first prototype write.
- R7: The load phase issues N_PROTO cell writes in consecutive cycles. Write k has cell_sel = k and cell_data = word SCAN_LEN+CFG_WORDS+k.
- R8: Each classify period holds cls_en high for exactly INTERVAL consecutive cycles, and refresh begins in the next cycle. A ref_done pulse during classify has no effect.
- R9: If sw_ext = 0 when the interval expires, an internal refresh runs:
  - ref_req stays high with cls_en low and no cell writes until ref_done is seen.
  - cls_en is high in the cycle after ref_done is sampled.
- R10: If sw_ext = 1 when the interval expires, an external refresh runs:
  - ref_req is high for exactly N_PROTO cycles, during which the same writes as in R7 are issued in the same order.
  - Classification then resumes without waiting for ref_done.
- R11: cls_en and ref_req are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_test | input | 1 | Scan self-test enable switch |
| sw_ext | input | 1 | 1 = external refresh, 0 = internal refresh |
| mem_addr | output | AW | Configuration memory word address |
| mem_rdata | input | DW | Configuration memory data, valid in the same cycle |
| scan_en | output | 1 | Scan chain shift enable |
| scan_sdo | output | 1 | Serial data into the scan chain |
| scan_sdi | input | 1 | Serial data returned by the scan chain |
| cfg_we | output | 1 | Decoder/kernel setting write strobe |
| cfg_sel | output | CSW | Setting register index |
| cfg_data | output | DW | Setting value |
| ptr_rst | output | 1 | Row/column pointer reset pulse |
| cell_we | output | 1 | Prototype cell write strobe |
| cell_sel | output | PSW | Prototype cell index |
| cell_data | output | DW | Prototype value |
| cls_en | output | 1 | Classification enable |
| ref_req | output | 1 | Refresh request |
| ref_done | input | 1 | Internal refresh complete |
| test_fail | output | 1 | Sticky scan self-test failure flag |

## Verification
The hardest situation to reach is the HALT state. It needs the returned scan stream to disagree with what was sent, which a healthy chain never does. The bench therefore models the scan chain as a shift register and can invert its output. This forces mismatches on every compare cycle. The bench then watches that the block stays silent for a long stretch after the verdict. A second hard corner is the interaction of ref_done with the classify timer, and of the refresh switch with an interval already in progress. The bench pulses ref_done in the middle of a classify period. It also flips the refresh switch between two periods. Both are done while a monitor measures the exact length of every classify and refresh window.

// File: rtl/clsup_pkg.sv
package clsup_pkg;

    typedef enum logic [3:0] {
        ST_BOOT,
        ST_FILL,
        ST_DRAIN,
        ST_VERDICT,
        ST_HALT,
        ST_CFG,
        ST_PTR,
        ST_LOAD,
        ST_RUN,
        ST_IREF,
        ST_XREF
    } clsup_state_e;

endpackage

// File: rtl/clsup_idx.sv
// Walking index shared by every sequenced phase: steps by one when told,
// otherwise returns to zero.
module clsup_idx #(
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [IW-1:0] q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (step) begin
            q <= q + 1'b1;
        end else begin
            q <= '0;
        end
    end

endmodule

// File: rtl/clsup_timer.sv
// Classify-period timer: counts while run is high and flags the last cycle.
module clsup_timer #(
    parameter int INTERVAL = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);

    generate
        if (INTERVAL < 2) begin : g_single
            assign expire = run;
        end else begin : g_count
            localparam int TW = $clog2(INTERVAL);
            logic [TW-1:0] cnt_q;

            always_ff @(posedge clk) begin
                if (!rst_n || !run) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assign expire = run && (cnt_q == TW'(INTERVAL - 1));
        end
    endgenerate

endmodule

// File: rtl/clsup_scan_cmp.sv
// Compares returned scan bits with the sent pattern and keeps a sticky flag.
module clsup_scan_cmp (
    input  logic clk,
    input  logic rst_n,
    input  logic cmp_en,
    input  logic sent,
    input  logic got,
    output logic fail
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fail <= 1'b0;
        end else if (cmp_en && (sent != got)) begin
            fail <= 1'b1;
        end
    end

endmodule

// File: rtl/clsup_ctrl.sv
// Supervisory sequencer for an analog prototype classifier array.
// All count parameters must be at least 2.
module clsup_ctrl
    import clsup_pkg::*;
#(
    parameter  int SCAN_LEN  = 8,
    parameter  int CFG_WORDS = 4,
    parameter  int N_PROTO   = 16,
    parameter  int DW        = 8,
    parameter  int INTERVAL  = 20,
    localparam int MEM_WORDS = SCAN_LEN + CFG_WORDS + N_PROTO,
    localparam int AW        = $clog2(MEM_WORDS),
    localparam int CSW       = $clog2(CFG_WORDS),
    localparam int PSW       = $clog2(N_PROTO)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sw_test,
    input  logic           sw_ext,
    output logic [AW-1:0]  mem_addr,
    input  logic [DW-1:0]  mem_rdata,
    output logic           scan_en,
    output logic           scan_sdo,
    input  logic           scan_sdi,
    output logic           cfg_we,
    output logic [CSW-1:0] cfg_sel,
    output logic [DW-1:0]  cfg_data,
    output logic           ptr_rst,
    output logic           cell_we,
    output logic [PSW-1:0] cell_sel,
    output logic [DW-1:0]  cell_data,
    output logic           cls_en,
    output logic           ref_req,
    input  logic           ref_done,
    output logic           test_fail
);

    localparam int CFG_BASE = SCAN_LEN;
    localparam int PRO_BASE = SCAN_LEN + CFG_WORDS;
    localparam int MAX_AB   = (SCAN_LEN > CFG_WORDS) ? SCAN_LEN : CFG_WORDS;
    localparam int MAXC     = (MAX_AB > N_PROTO) ? MAX_AB : N_PROTO;
    localparam int IW       = $clog2(MAXC);

    clsup_state_e  state_q, state_d;
    logic [IW-1:0] idx_q;
    logic          idx_step;
    logic          last_scan, last_cfg, last_pro;
    logic          expire;
    logic          fail_q;

    assign last_scan = (idx_q == IW'(SCAN_LEN - 1));
    assign last_cfg  = (idx_q == IW'(CFG_WORDS - 1));
    assign last_pro  = (idx_q == IW'(N_PROTO - 1));

    // Phase index
    clsup_idx #(.IW(IW)) u_idx (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (idx_step),
        .q     (idx_q)
    );

    // Classify interval
    clsup_timer #(.INTERVAL(INTERVAL)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state_q == ST_RUN),
        .expire (expire)
    );

    // Scan compare with sticky failure
    clsup_scan_cmp u_cmp (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmp_en (state_q == ST_DRAIN),
        .sent   (mem_rdata[0]),
        .got    (scan_sdi),
        .fail   (fail_q)
    );

    assign test_fail = fail_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_BOOT;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and index stepping
    always_comb begin
        state_d  = state_q;
        idx_step = 1'b0;
        unique case (state_q)
            ST_BOOT:    state_d = sw_test ? ST_FILL : ST_CFG;
            ST_FILL: begin
                idx_step = !last_scan;
                if (last_scan) state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                idx_step = !last_scan;
                if (last_scan) state_d = ST_VERDICT;
            end
            ST_VERDICT: state_d = fail_q ? ST_HALT : ST_CFG;
            ST_HALT:    state_d = ST_HALT;
            ST_CFG: begin
                idx_step = !last_cfg;
                if (last_cfg) state_d = ST_PTR;
            end
            ST_PTR:     state_d = ST_LOAD;
            ST_LOAD: begin
                idx_step = !last_pro;
                if (last_pro) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (expire) state_d = sw_ext ? ST_XREF : ST_IREF;
            end
            ST_IREF: begin
                if (ref_done) state_d = ST_RUN;
            end
            ST_XREF: begin
                idx_step = !last_pro;
                if (last_pro) state_d = ST_RUN;
            end
            default:    state_d = ST_BOOT;
        endcase
    end

    // Outputs
    always_comb begin
        mem_addr  = '0;
        scan_en   = 1'b0;
        scan_sdo  = 1'b0;
        cfg_we    = 1'b0;
        cfg_sel   = '0;
        cfg_data  = '0;
        ptr_rst   = 1'b0;
        cell_we   = 1'b0;
        cell_sel  = '0;
        cell_data = '0;
        cls_en    = 1'b0;
        ref_req   = 1'b0;
        unique case (state_q)
            ST_FILL: begin
                mem_addr = AW'(idx_q);
                scan_en  = 1'b1;
                scan_sdo = mem_rdata[0];
            end
            ST_DRAIN: begin
                mem_addr = AW'(idx_q);
                scan_en  = 1'b1;
            end
            ST_CFG: begin
                mem_addr = AW'(CFG_BASE) + AW'(idx_q);
                cfg_we   = 1'b1;
                cfg_sel  = CSW'(idx_q);
                cfg_data = mem_rdata;
            end
            ST_PTR:  ptr_rst = 1'b1;
            ST_LOAD, ST_XREF: begin
                mem_addr  = AW'(PRO_BASE) + AW'(idx_q);
                cell_we   = 1'b1;
                cell_sel  = PSW'(idx_q);
                cell_data = mem_rdata;
                ref_req   = (state_q == ST_XREF);
            end
            ST_RUN:  cls_en  = 1'b1;
            ST_IREF: ref_req = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/clsup_ctrl_chk.sv
module clsup_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic scan_en,
    input logic cfg_we,
    input logic ptr_rst,
    input logic cell_we,
    input logic cls_en,
    input logic ref_req,
    input logic ref_done,
    input logic test_fail
);

    a_r11_cls_ref_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(cls_en && ref_req));

    a_r3_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        test_fail |=> test_fail);

    a_r3_fail_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        test_fail |-> !(cls_en || cfg_we || cell_we || ref_req));

    a_r6_ptr_single: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_rst |=> !ptr_rst);

    a_r6_ptr_then_load: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_rst |=> cell_we);

    a_r9_iref_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && !cell_we && !ref_done) |=> ref_req);

    a_r2_scan_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |-> !(cfg_we || cell_we || cls_en || ref_req));

endmodule

bind clsup_ctrl clsup_ctrl_chk u_chk (.*);

// File: tb/clsup_ctrl_tb.sv
`timescale 1ns/1ps
module clsup_ctrl_tb;

    localparam int SL = 8;
    localparam int CW = 4;
    localparam int NP = 16;
    localparam int IV = 20;
    localparam int AW = $clog2(SL + CW + NP);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sw_test = 1'b1, sw_ext = 1'b0, ref_done = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_rdata, cfg_data, cell_data;
    logic          scan_en, scan_sdo, scan_sdi;
    logic          cfg_we, ptr_rst, cell_we, cls_en, ref_req, test_fail;
    logic [1:0]    cfg_sel;
    logic [3:0]    cell_sel;
    logic [SL-1:0] chain;
    logic          fault = 1'b0;
    bit            exp_ext = 1'b0;

    int n_chk = 0, n_fail = 0;
    int scan_cnt, cfg_cnt, ptr_cnt, load_cnt, run_len, ref_len, ref_wr;
    bit prev_cls, prev_ref;

    always #4 clk = ~clk;

    function automatic logic [7:0] memf(input int a);
        return 8'((a * 37 + 11) ^ (a >> 2));
    endfunction

    always_comb mem_rdata = memf(int'(mem_addr));

    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else if (scan_en) chain <= {chain[SL-2:0], scan_sdo};
    end
    assign scan_sdi = chain[SL-1] ^ fault;

    clsup_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .sw_test(sw_test), .sw_ext(sw_ext),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .scan_en(scan_en), .scan_sdo(scan_sdo), .scan_sdi(scan_sdi),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .ptr_rst(ptr_rst), .cell_we(cell_we), .cell_sel(cell_sel),
        .cell_data(cell_data), .cls_en(cls_en), .ref_req(ref_req),
        .ref_done(ref_done), .test_fail(test_fail)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor at the falling edge
    always @(negedge clk) begin
        if (!rst_n) begin
            scan_cnt = 0; cfg_cnt = 0; ptr_cnt = 0; load_cnt = 0;
            run_len = 0; ref_len = 0; ref_wr = 0; prev_cls = 0; prev_ref = 0;
        end else begin
            if (scan_en) begin
                logic [7:0] w;
                logic eb;
                w  = memf(scan_cnt);
                eb = (scan_cnt < SL) ? w[0] : 1'b0;
                chk(scan_sdo == eb, "R2 scan bit", scan_sdo, eb);
                scan_cnt++;
            end
            if (cfg_we) begin
                chk(cfg_sel == 2'(cfg_cnt) && cfg_data == memf(SL + cfg_cnt) && load_cnt == 0,
                    "R5 config write", cfg_data, memf(SL + cfg_cnt));
                cfg_cnt++;
            end
            if (ptr_rst) begin
                chk(cfg_cnt == CW && load_cnt == 0 && ptr_cnt == 0, "R6 pointer reset order",
                    cfg_cnt, CW);
                ptr_cnt++;
            end
            if (cell_we && !ref_req) begin
                chk(ptr_cnt == 1 && cell_sel == 4'(load_cnt)
                    && cell_data == memf(SL + CW + load_cnt),
                    "R7 load write", cell_data, memf(SL + CW + load_cnt));
                load_cnt++;
            end
            if (cell_we && ref_req) begin
                chk(exp_ext && cell_sel == 4'(ref_wr) && cell_data == memf(SL + CW + ref_wr),
                    "R10 refresh write", cell_data, memf(SL + CW + ref_wr));
                ref_wr++;
            end
            if (cls_en && ref_req) chk(1'b0, "R11 exclusive", 1, 0);
            if (prev_cls && !cls_en) begin
                chk(run_len == IV, "R8 classify length", run_len, IV);
                chk(ref_req, "R8 refresh follows", ref_req, 1);
                run_len = 0;
            end
            if (prev_ref && !ref_req) begin
                if (exp_ext) chk(ref_len == NP && ref_wr == NP, "R10 external length", ref_len, NP);
                else         chk(ref_wr == 0, "R9 no writes in internal refresh", ref_wr, 0);
                chk(cls_en, "R9 R10 classify resumes", cls_en, 1);
                ref_len = 0; ref_wr = 0;
            end
            if (cls_en)  run_len++;
            if (ref_req) ref_len++;
            prev_cls = cls_en;
            prev_ref = ref_req;
        end
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic reset_dut(input logic t, input logic f);
        rst_n = 1'b0; sw_test = t; fault = f; sw_ext = 1'b0; exp_ext = 1'b0; ref_done = 1'b0;
        repeat (3) step();
        chk(!(cfg_we || cell_we || ptr_rst || scan_en || cls_en || ref_req || test_fail),
            "R1 outputs in reset", 1, 0);
        rst_n = 1'b1;
        chk(!(cfg_we || cell_we || ptr_rst || scan_en || cls_en || ref_req || test_fail),
            "R1 outputs after release", 1, 0);
    endtask

    task automatic wait_cls();
        for (int i = 0; i < 400 && !cls_en; i++) step();
    endtask

    task automatic wait_ref();
        for (int i = 0; i < 400 && !ref_req; i++) step();
    endtask

    initial begin
        // Self-test on, healthy chain, internal then external refresh
        reset_dut(1'b1, 1'b0);
        wait_cls();
        chk(cls_en, "R7 init reaches classify", cls_en, 1);
        chk(scan_cnt == 2 * SL, "R2 scan cycles", scan_cnt, 2 * SL);
        chk(test_fail == 1'b0, "R3 no fail on healthy chain", test_fail, 0);
        chk(cfg_cnt == CW, "R5 config count", cfg_cnt, CW);
        chk(ptr_cnt == 1, "R6 pulse count", ptr_cnt, 1);
        chk(load_cnt == NP, "R7 load count", load_cnt, NP);
        repeat (5) step();
        ref_done = 1'b1; step(); ref_done = 1'b0;
        chk(cls_en && !ref_req, "R8 ref_done ignored in classify", cls_en, 1);
        wait_ref();
        for (int i = 0; i < 6; i++) begin
            step();
            chk(ref_req && !cls_en, "R9 refresh held", ref_req, 1);
        end
        ref_done = 1'b1; step(); ref_done = 1'b0;
        chk(cls_en && !ref_req, "R9 classify after done", cls_en, 1);
        step();
        sw_ext = 1'b1; exp_ext = 1'b1;
        wait_ref();
        wait_cls();
        chk(cls_en, "R10 classify after external refresh", cls_en, 1);
        step();
        sw_ext = 1'b0; exp_ext = 1'b0;
        wait_ref();
        repeat (3) step();
        ref_done = 1'b1; step(); ref_done = 1'b0;
        chk(cls_en, "R9 internal after external", cls_en, 1);
        repeat (3) step();

        // Self-test off
        reset_dut(1'b0, 1'b0);
        wait_cls();
        chk(scan_cnt == 0, "R4 no scan when disabled", scan_cnt, 0);
        chk(cfg_cnt == CW && load_cnt == NP, "R4 init without test", load_cnt, NP);
        repeat (3) step();

        // Faulty chain
        reset_dut(1'b1, 1'b1);
        repeat (2 * SL + 10) step();
        chk(test_fail, "R3 fail flag set", test_fail, 1);
        chk(cfg_cnt == 0 && !cls_en, "R3 halted before config", cfg_cnt, 0);
        chk(scan_cnt == 2 * SL, "R2 scan cycles before halt", scan_cnt, 2 * SL);
        repeat (60) step();
        chk(test_fail && cfg_cnt == 0 && load_cnt == 0 && !cls_en && !ref_req,
            "R3 stays halted", test_fail, 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule